// File: doc/BRIEF.md
# Multi-Source Board Trigger Manager

This block merges every trigger source on a multi-channel acquisition board into one common trigger, so that all channels start an event in the same clock cycle and hold the same length and trigger position. Three kinds of source feed it: an external trigger pin that may be asynchronous to the sampling clock, a software trigger raised by a register write strobe, and one local trigger per channel from that channel's digital threshold comparator.

The external pin passes through a synchroniser and a rising-edge detector. The software strobe becomes a single-cycle pulse on its rising edge. The local triggers are gated by a per-channel enable mask and OR-combined, and their combined rise gives a single pulse. Each source that qualifies feeds a registered one-cycle trigger. The block drives that trigger to every channel and to a trigger-out pin. The trigger is held off while the acquisition logic reports busy. No interface carries a data stream, so every pin is a plain control level or strobe, with no valid/ready handshake and no back-pressure.

Top module: `trig_hub`

## Requirements
- R1: In every cycle, all bits of `chan_trig` and `trig_out` carry the same value.
- R2: A rising edge on `sw_wr` with `sw_en` high gives exactly one trigger, visible after the next clock edge. A strobe held high for several cycles still gives only one trigger.
- R3: While `sw_en` is low, software write strobes give no trigger.
- R4: `ext_trig_in` is resampled through `SYNC_STAGES` (default 2) flops. A rise first sampled at clock edge k gives one trigger visible after edge k+`SYNC_STAGES`. A level held high gives no further triggers.
- R5: While `ext_en` is low, edges on `ext_trig_in` give no trigger.
- R6: Bit i of `ch_mask` (1 = enabled) gates `local_trig[i]`. A rise of the masked OR gives a trigger after the next edge. A rise on a channel whose mask bit is 0 has no effect.
- R7: A masked local trigger held high gives only one trigger. A new trigger needs the masked OR to fall and rise again.
- R8: Sources that qualify in the same cycle give one single-cycle trigger, not several.
- R9: A trigger whose source qualifies in a cycle where `busy` is sampled high is dropped. It is not delayed to the cycle after `busy` falls.
- R10: While `rst_n` is low, and after reset until a source qualifies, `trig_out` and `chan_trig` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig_in | input | 1 | External trigger pin, may be asynchronous |
| ext_en | input | 1 | Include external trigger in the common trigger |
| sw_wr | input | 1 | Software trigger register write strobe |
| sw_en | input | 1 | Include software trigger in the common trigger |
| local_trig | input | NCH | Per-channel threshold trigger levels |
| ch_mask | input | NCH | Per-channel local trigger enable, 1 = enabled |
| busy | input | 1 | Acquisition busy; holds off triggers |
| chan_trig | output | NCH | Common trigger to each channel |
| trig_out | output | 1 | Trigger-out pin, copy of the common trigger |

## Verification
The hardest case to reach from the ports is exact external trigger timing. A rise on the pin appears only after the synchroniser and edge stages, so the bench drives the pin at a known cycle count and expects the trigger exactly `SYNC_STAGES` + 1 edges later. Any extra or missing flop stage shows up as a cycle mismatch in the scoreboard. The busy drop case is reached by raising `busy` in the same cycle as a software strobe and holding it for a few cycles, so that a design which queued the trigger would fire late and be caught as an unexpected trigger.

// File: rtl/trig_hub_pkg.sv
package trig_hub_pkg;
  typedef struct packed {
    logic ext;
    logic sw;
    logic loc;
  } trig_src_t;
endpackage

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign pulse = lvl & ~prev;

  // R2, R4, R7: a held level yields a single pulse
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic edge_pulse
);
  logic [SYNC_STAGES-1:0] chain;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= ext_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  rise_pulse u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (chain[SYNC_STAGES-1]),
    .pulse (edge_pulse)
  );

  // R4: one pulse per synchronised rising edge
  p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/local_combine.sv
module local_combine #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] local_trig,
  input  logic [NCH-1:0] ch_mask,
  output logic           loc_pulse
);
  logic [NCH-1:0] gated;
  logic           any_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_gate
    assign gated[g] = local_trig[g] & ch_mask[g];
  end

  assign any_hit = |gated;

  rise_pulse u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (any_hit),
    .pulse (loc_pulse)
  );
endmodule

// File: rtl/trig_hub.sv
module trig_hub
  import trig_hub_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_trig_in,
  input  logic           ext_en,
  input  logic           sw_wr,
  input  logic           sw_en,
  input  logic [NCH-1:0] local_trig,
  input  logic [NCH-1:0] ch_mask,
  input  logic           busy,
  output logic [NCH-1:0] chan_trig,
  output logic           trig_out
);
  logic      ext_edge;
  logic      sw_pulse;
  logic      loc_pulse;
  trig_src_t src;
  logic      fire;
  logic      trig_q;

  ext_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_in     (ext_trig_in),
    .edge_pulse (ext_edge)
  );

  rise_pulse u_sw (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sw_wr),
    .pulse (sw_pulse)
  );

  local_combine #(.NCH(NCH)) u_loc (
    .clk        (clk),
    .rst_n      (rst_n),
    .local_trig (local_trig),
    .ch_mask    (ch_mask),
    .loc_pulse  (loc_pulse)
  );

  always_comb begin
    src.ext = ext_edge & ext_en;
    src.sw  = sw_pulse & sw_en;
    src.loc = loc_pulse;
    fire    = |src;
  end

  // R8, R9: one registered trigger, dropped while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= fire & ~busy;
  end

  // R1: identical fan-out to every channel
  for (genvar g = 0; g < NCH; g++) begin : g_fan
    assign chan_trig[g] = trig_q;
  end
  assign trig_out = trig_q;

  p_busy_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !trig_out);

  // R3, R5, R6: nothing enabled and no masked local activity means no trigger
  p_gated_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !sw_en && ((local_trig & ch_mask) == '0)) |=> !trig_out);

  p_sw_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_wr) && sw_en && !busy) |=> trig_out);
endmodule

// File: tb/tb_trig_hub.sv
module tb_trig_hub;
  localparam int NCH = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_trig_in = 1'b0, ext_en = 1'b0, sw_wr = 1'b0, sw_en = 1'b0, busy = 1'b0;
  logic [NCH-1:0] local_trig = '0, ch_mask = '0;
  logic [NCH-1:0] chan_trig;
  logic trig_out;

  always #10 clk = ~clk;

  trig_hub #(.NCH(NCH), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .ext_trig_in(ext_trig_in), .ext_en(ext_en),
    .sw_wr(sw_wr), .sw_en(sw_en), .local_trig(local_trig), .ch_mask(ch_mask),
    .busy(busy), .chan_trig(chan_trig), .trig_out(trig_out)
  );

  typedef struct {
    int    cyc;
    string req;
  } exp_t;

  exp_t q[$];
  int cnt = 0;
  int checks = 0;
  int errors = 0;
  int seen = 0;
  bit done = 1'b0;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares produced triggers against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (trig_out === 1'b1) begin
        exp_t e;
        seen++;
        chk(chan_trig === {NCH{1'b1}}, "R1 fan-out", int'(chan_trig), 255);
        if (q.size() == 0) chk(1'b0, "unexpected trigger", cnt, -1);
        else begin
          e = q.pop_front();
          chk(e.cyc == cnt, e.req, cnt, e.cyc);
        end
      end else begin
        if (chan_trig !== '0) chk(1'b0, "R1 fan-out", int'(chan_trig), 0);
        while (q.size() > 0 && q[0].cyc < cnt) begin
          exp_t m;
          m = q.pop_front();
          chk(1'b0, {m.req, " missed"}, cnt, m.cyc);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int lat, input string req);
    exp_t e;
    e.cyc = cnt + lat;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic sw_write(input int len, input bit expect_it, input string req);
    if (expect_it) push(1, req);
    sw_wr = 1'b1;
    tick(len);
    sw_wr = 1'b0;
  endtask

  task automatic ext_pulse(input int len, input bit expect_it, input string req);
    if (expect_it) push(SYNC + 1, req);
    ext_trig_in = 1'b1;
    tick(len);
    ext_trig_in = 1'b0;
  endtask

  task automatic loc_pulse(input logic [NCH-1:0] bits, input int len,
                           input bit expect_it, input string req);
    if (expect_it) push(1, req);
    local_trig = bits;
    tick(len);
    local_trig = '0;
  endtask

  task automatic settle(input int base, input int n_new, input string req);
    tick(8);
    chk(seen == base + n_new, req, seen - base, n_new);
  endtask

  initial begin
    int base;
    tick(3);
    chk(trig_out === 1'b0 && chan_trig === '0, "R10 in reset", int'(trig_out), 0);
    rst_n = 1'b1;
    tick(3);
    chk(trig_out === 1'b0 && chan_trig === '0, "R10 after reset", int'(trig_out), 0);
    ext_en = 1'b1; sw_en = 1'b1; ch_mask = 8'h08;
    tick(2);

    base = seen; sw_write(1, 1'b1, "R2 single write"); settle(base, 1, "R2 count");
    base = seen; sw_write(5, 1'b1, "R2 held write");   settle(base, 1, "R2 held count");
    sw_en = 1'b0;
    base = seen; sw_write(1, 1'b0, "R3");              settle(base, 0, "R3 disabled sw");
    sw_en = 1'b1;

    base = seen; ext_pulse(1, 1'b1, "R4 ext latency"); settle(base, 1, "R4 count");
    base = seen; ext_pulse(6, 1'b1, "R4 ext held");    settle(base, 1, "R4 held count");
    ext_en = 1'b0;
    base = seen; ext_pulse(3, 1'b0, "R5");             settle(base, 0, "R5 disabled ext");
    ext_en = 1'b1;

    base = seen; loc_pulse(8'h08, 1, 1'b1, "R6 enabled ch3"); settle(base, 1, "R6 count");
    base = seen; loc_pulse(8'h20, 2, 1'b0, "R6");             settle(base, 0, "R6 masked ch5");
    ch_mask = 8'hA1;
    base = seen; loc_pulse(8'h80, 1, 1'b1, "R6 enabled ch7"); settle(base, 1, "R6 ch7 count");
    base = seen; loc_pulse(8'h01, 6, 1'b1, "R7 held local"); settle(base, 1, "R7 held count");
    base = seen;
    local_trig = 8'h01; push(1, "R7 first rise"); tick(2);
    local_trig = 8'h21; tick(2);
    local_trig = 8'h00; tick(1);
    local_trig = 8'h20; push(1, "R7 re-rise"); tick(1);
    local_trig = 8'h00;
    settle(base, 2, "R7 rise count");

    base = seen;
    push(1, "R8 coincident");
    sw_wr = 1'b1; local_trig = 8'h80;
    tick(1);
    sw_wr = 1'b0; local_trig = '0;
    settle(base, 1, "R8 single trigger");

    base = seen;
    busy = 1'b1;
    sw_write(1, 1'b0, "R9");
    tick(3);
    busy = 1'b0;
    settle(base, 0, "R9 dropped not delayed");
    base = seen; sw_write(1, 1'b1, "R9 after busy"); settle(base, 1, "R9 recovery");

    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule